// File: doc/BRIEF.md
# Display Bias Toggle Counter

This block produces the alternating bias level for a passive display panel and watches how often that level has flipped. Every frame-end strobe inverts the bias output while the block is enabled. A down counter, seeded from a programmable count, loses one for each inversion. When the counter runs out, a sticky done flag is raised and the counter is reseeded from the count field. The counter then stays frozen until software writes a one to clear the flag. The bias output keeps inverting while the counter is frozen.

A programmed count of zero turns reporting off: the flag never rises. An interrupt request is the done flag gated by a mask bit. The count field is sampled only at two moments: when the block is enabled, and at the moment the counter expires. A change to the field at any other time affects only the next load.

Top module: `acb_bias_counter`

## Requirements
- R1: After reset, bias_out, done_flag and irq are all 0.
- R2: While enable is 0, bias_out and done_flag stay 0, frame_end has no effect, and the counter is loaded from reload_cnt.
- R3: Each cycle with enable=1 and frame_end=1 inverts bias_out at the next clock edge. This holds whether or not the counter is frozen.
- R4: With a nonzero count N loaded, done_flag rises at the same edge as the Nth bias inversion counted since enable or since the last clear.
- R5: Once done_flag is set, further inversions do not advance the counter. After a clear, exactly N more inversions are needed to set the flag again.
- R6: If the loaded count is 0, done_flag never rises, however many strobes arrive.
- R7: A one on flag_clr clears done_flag at the next edge. If an expiry happens in the same cycle, the set wins.
- R8: irq equals done_flag AND irq_mask, combinationally.
- R9: The reload value is the reload_cnt value present at the expiry edge. Changing reload_cnt after expiry does not alter the count that follows the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; while low, the counter loads reload_cnt |
| frame_end | input | 1 | One-cycle frame-end strobe |
| reload_cnt | input | CNT_W | Programmed inversion count |
| flag_clr | input | 1 | Write-one-to-clear pulse for the done flag |
| irq_mask | input | 1 | Interrupt enable for the done flag |
| bias_out | output | 1 | Bias pin level |
| done_flag | output | 1 | Sticky count-reached flag |
| irq | output | 1 | Interrupt request |

## Verification
The bias level and the done flag both come from a single register stage, so each one answers a strobe or clear at the first clock edge after it. The irq output follows the flag and the mask within the same cycle. The bench drives every input on the falling edge and samples on the next falling edge, after exactly one rising edge has passed. It sweeps counts 0 to 6 against both mask settings and predicts the flag from the number of strobes issued, compared with the loaded count.

// File: rtl/acb_pkg.sv
package acb_pkg;
    // Default width of the programmed inversion count.
    localparam int unsigned ACB_CNT_W = 8;
endpackage

// File: rtl/acb_bias_toggle.sv
// acb_bias_toggle: inverts the bias pin level on every frame-end strobe
// while enabled. It holds the level at 0 while disabled.
// Assumes frame_end is a single-cycle strobe in the clk domain.
module acb_bias_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic frame_end,
    output logic bias,
    output logic flip
);
    // An inversion happens this cycle.
    assign flip = enable & frame_end;

    // Bias level register.
    always_ff @(posedge clk) begin
        if (!rst_n)       bias <= 1'b0;
        else if (!enable) bias <= 1'b0;
        else if (flip)    bias <= ~bias;
    end

    a_r3_bias_inverts: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && frame_end) |=> (bias != $past(bias)));
    a_r2_bias_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !bias);
endmodule

// File: rtl/acb_down_counter.sv
// acb_down_counter: counts bias inversions down from a programmed value.
// Reaching zero pulses expire and reseeds the counter from the field.
// The counter stays frozen while halt is high.
// Assumes halt is the sticky done flag. A loaded value of zero never counts.
module acb_down_counter #(
    parameter int unsigned CNT_W = acb_pkg::ACB_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             flip,
    input  logic             halt,
    input  logic [CNT_W-1:0] field,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             step;

    // A counted inversion: active, not frozen, nonzero count.
    assign step   = enable & flip & ~halt & (cnt_q != '0);
    assign expire = step & (cnt_q == ONE);

    // Count register: load while disabled, reseed on expiry, else decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (!enable) cnt_q <= field;
        else if (expire)  cnt_q <= field;
        else if (step)    cnt_q <= cnt_q - ONE;
    end

    a_r5_frozen_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && halt) |=> (cnt_q == $past(cnt_q)));
    a_r9_reseed_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt_q == $past(field)));
endmodule

// File: rtl/acb_status_flag.sv
// acb_status_flag: sticky done flag. It is set on expiry and cleared by a
// write-one pulse. A set takes priority over a clear in the same cycle.
// Assumes expire is a single-cycle pulse.
module acb_status_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic expire,
    input  logic clr,
    output logic flag
);
    // Flag register with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (!enable) flag <= 1'b0;
        else if (expire)  flag <= 1'b1;
        else if (clr)     flag <= 1'b0;
    end

    a_r4_set_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && expire) |=> flag);
    a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && clr && !expire) |=> !flag);
    a_r6_rise_needs_expire: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(expire));
endmodule

// File: rtl/acb_bias_counter.sv
// acb_bias_counter: top of the display bias toggle counter. It wires the
// bias toggler, the down counter and the sticky flag together, and gates
// the interrupt with a mask.
// Assumes all inputs are synchronous to clk.
module acb_bias_counter #(
    parameter int unsigned CNT_W = acb_pkg::ACB_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             frame_end,
    input  logic [CNT_W-1:0] reload_cnt,
    input  logic             flag_clr,
    input  logic             irq_mask,
    output logic             bias_out,
    output logic             done_flag,
    output logic             irq
);
    logic flip;
    logic expire;

    acb_bias_toggle u_toggle (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .frame_end (frame_end),
        .bias      (bias_out),
        .flip      (flip)
    );

    acb_down_counter #(.CNT_W(CNT_W)) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .flip   (flip),
        .halt   (done_flag),
        .field  (reload_cnt),
        .expire (expire)
    );

    acb_status_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .expire (expire),
        .clr    (flag_clr),
        .flag   (done_flag)
    );

    // Masked interrupt request.
    assign irq = done_flag & irq_mask;

    a_r2_flag_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !done_flag);
    a_r8_irq_follows_mask: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_mask |-> !irq);
endmodule

// File: tb/acb_bias_counter_tb.sv
module acb_bias_counter_tb;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic frame_end = 1'b0;
    logic [CNT_W-1:0] reload_cnt = '0;
    logic flag_clr = 1'b0;
    logic irq_mask = 1'b0;
    logic bias_out, done_flag, irq;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    acb_bias_counter #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .frame_end(frame_end),
        .reload_cnt(reload_cnt), .flag_clr(flag_clr), .irq_mask(irq_mask),
        .bias_out(bias_out), .done_flag(done_flag), .irq(irq)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // One cycle with a strobe (and an optional clear), then back to idle.
    task automatic pulse(input logic clr);
        @(negedge clk); frame_end = 1'b1; flag_clr = clr;
        @(negedge clk); frame_end = 1'b0; flag_clr = 1'b0;
    endtask

    task automatic clear_only();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic expb;
        repeat (3) @(negedge clk);
        chk("R1 bias", bias_out, 1'b0);
        chk("R1 flag", done_flag, 1'b0);
        chk("R1 irq", irq, 1'b0);
        rst_n = 1'b1;
        for (int n = 0; n <= 6; n++) begin
            for (int m = 0; m < 2; m++) begin
                @(negedge clk); enable = 1'b0; irq_mask = m[0];
                reload_cnt = CNT_W'(n);
                pulse(1'b0);
                chk("R2 bias off", bias_out, 1'b0);
                chk("R2 flag off", done_flag, 1'b0);
                @(negedge clk); enable = 1'b1;
                expb = 1'b0;
                // First pass: count from enable.
                for (int k = 1; k <= n + 3; k++) begin
                    pulse(1'b0);
                    expb = ~expb;
                    chk("R3 bias", bias_out, expb);
                    chk((n == 0) ? "R6 zero" : (k > n ? "R5 frozen" : "R4 count"),
                        done_flag, (n != 0) && (k >= n));
                    chk("R8 irq", irq, (n != 0) && (k >= n) && m[0]);
                end
                if (n != 0) begin
                    // Change the field after expiry; the reseed used n.
                    @(negedge clk); reload_cnt = CNT_W'(n + 2);
                    clear_only();
                    chk("R7 clear", done_flag, 1'b0);
                    chk("R8 irq cleared", irq, 1'b0);
                    for (int k = 1; k <= n; k++) begin
                        // The last strobe carries a clear: set must win.
                        pulse(k == n);
                        expb = ~expb;
                        chk("R3 bias", bias_out, expb);
                        chk(k == n ? "R7 set wins" : "R9 reseed", done_flag, k == n);
                    end
                end
            end
        end
        @(negedge clk); enable = 1'b0;
        @(negedge clk);
        chk("R2 disable clears", done_flag, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule